// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Unit

This block turns the eight input pins of a general-purpose port into one interrupt request line. Every pin first passes through a two-stage synchroniser. A 3-bit trigger selector for each pin then decides which input condition raises that pin's pending flag. The choices are a level, an edge, a constant request, or nothing.

Pending flags are sticky. Software clears them by writing ones to the pending address. A flag whose trigger condition is still true in the same cycle stays set, so a level-triggered pin re-asserts until its input changes. An enable mask gates the pending flags into a masked status value. The registered OR of that status drives the request line.

Configuration uses a plain single-cycle register port. A write takes effect on the clock edge where `wr_en_i` is high. Reads are combinational from `rd_addr_i`. No handshake is needed: the port never stalls and every write is accepted.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, all trigger selectors read 0, the mask reads 0, no flag is pending, `irq_o` is 0, and the synchroniser stages hold 0.
- R2: Selector encoding per pin: 0 off, 1 level high, 2 level low, 3 always, 4 rising edge, 5 falling edge, 6 either edge, 7 behaves as off. An off pin never raises its flag.
- R3: In level-high mode the flag is raised on every cycle the synchronised input is 1. In level-low mode it is raised on every cycle the synchronised input is 0.
- R4: In always mode the flag is raised on every cycle, starting the cycle after the selector is written.
- R5: Edge modes compare the synchronised input with its value one cycle earlier: rising is 0 then 1, falling is 1 then 0, either is any difference.
- R6: A pin value sampled at clock edge E1 becomes the synchronised value after edge E2. A trigger it causes sets the pending flag at edge E3.
- R7: Writing to address 2 clears each pending flag whose data bit is 1. A 0 bit leaves its flag alone. If a trigger occurs in the same cycle as the clear, the trigger wins and the flag stays set.
- R8: Address 3 reads the pending flags AND the mask. Clearing a mask bit removes that pin from the status and the request but keeps its selector and its pending flag.
- R9: `irq_o` is the OR of the masked status as it stood before the previous clock edge, i.e. one register later.
- R10: Address map. Address 0 is the selectors, read/write, with pin i at bits 3i+2..3i. Address 1 is the mask, read/write, with pin i at bit i. Address 2 reads the raw pending flags and a write to it clears flags. Address 3 is read-only, and writes to it change nothing. Unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS (8) | Asynchronous port inputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | DATA_W (32) | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | DATA_W (32) | Combinational read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A pin change that is present at edge E1 shows up as a pending flag only after edge E3 and on `irq_o` after edge E4. Register writes are visible on reads right after their own edge, and the request responds to them one edge later. The bench keeps a behavioural model that it advances on each rising edge. It compares outputs five nanoseconds later, while inputs change only on falling edges. Directed checks are placed on the falling edge of the exact cycle counted from these latencies, both just before and just after the expected change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    TRIG_OFF  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_SET  = 3'd3,
    TRIG_RISE = 3'd4,
    TRIG_FALL = 3'd5,
    TRIG_BOTH = 3'd6,
    TRIG_RSVD = 3'd7
  } trig_mode_e;

  typedef logic [1:0] reg_addr_t;

  localparam reg_addr_t REG_MODE  = 2'd0;
  localparam reg_addr_t REG_MASK  = 2'd1;
  localparam reg_addr_t REG_PEND  = 2'd2;
  localparam reg_addr_t REG_MSTAT = 2'd3;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] cur_o,
  output logic [NPINS-1:0] prev_o
);
  logic [NPINS-1:0] stage1_q;
  logic [NPINS-1:0] stage2_q;
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= pin_i;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign cur_o  = stage2_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 8,
  localparam int MODE_BITS = NPINS * MODE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic [MODE_BITS-1:0] mode_i,
  input  logic [NPINS-1:0]     cur_i,
  input  logic [NPINS-1:0]     prev_i,
  output logic [NPINS-1:0]     trig_o
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    trig_mode_e sel;
    assign sel = trig_mode_e'(mode_i[g*MODE_W +: MODE_W]);

    always_comb begin
      case (sel)
        TRIG_HIGH: trig_o[g] = cur_i[g];
        TRIG_LOW:  trig_o[g] = ~cur_i[g];
        TRIG_SET:  trig_o[g] = 1'b1;
        TRIG_RISE: trig_o[g] = cur_i[g] & ~prev_i[g];
        TRIG_FALL: trig_o[g] = ~cur_i[g] & prev_i[g];
        TRIG_BOTH: trig_o[g] = cur_i[g] ^ prev_i[g];
        default:   trig_o[g] = 1'b0;
      endcase
    end

    // R5
    rise_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (sel == TRIG_RISE && trig_o[g]) |-> (cur_i[g] && !$past(cur_i[g])));

    // R5
    fall_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (sel == TRIG_FALL && trig_o[g]) |-> (!cur_i[g] && $past(cur_i[g])));
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int DATA_W = 32,
  localparam int MODE_BITS = NPINS * MODE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 wr_en_i,
  input  reg_addr_t            wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  reg_addr_t            rd_addr_i,
  input  logic [NPINS-1:0]     trig_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic [MODE_BITS-1:0] mode_o,
  output logic [NPINS-1:0]     mask_o,
  output logic [NPINS-1:0]     pend_o
);
  logic [MODE_BITS-1:0] mode_q;
  logic [NPINS-1:0]     mask_q;
  logic [NPINS-1:0]     pend_q;
  logic [NPINS-1:0]     ack_vec;
  logic                 unused_hi;

  assign unused_hi = ^wr_data_i;

  assign ack_vec = (wr_en_i && wr_addr_i == REG_PEND) ? wr_data_i[NPINS-1:0] : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q <= '0;
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == REG_MODE) mode_q <= wr_data_i[MODE_BITS-1:0];
      if (wr_en_i && wr_addr_i == REG_MASK) mask_q <= wr_data_i[NPINS-1:0];
      pend_q <= (pend_q & ~ack_vec) | trig_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      REG_MODE:  rd_data_o = DATA_W'(mode_q);
      REG_MASK:  rd_data_o = DATA_W'(mask_q);
      REG_PEND:  rd_data_o = DATA_W'(pend_q);
      default:   rd_data_o = DATA_W'(pend_q & mask_q);
    endcase
  end

  assign mode_o = mode_q;
  assign mask_o = mask_q;
  assign pend_o = pend_q;

  // R7
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (|(ack_vec & ~trig_i)) |=> ((pend_q & $past(ack_vec & ~trig_i)) == '0));

  // R7
  trig_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (|trig_i) |=> ((pend_q & $past(trig_i)) == $past(trig_i)));

  // R7
  pend_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (|(pend_q & ~ack_vec)) |=> ((pend_q & $past(pend_q & ~ack_vec)) == $past(pend_q & ~ack_vec)));

  // R8
  mask_keeps_mode_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && wr_addr_i == REG_MASK) |=> $stable(mode_q));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int MODE_BITS = NPINS * MODE_W;

  logic [NPINS-1:0]     cur_w;
  logic [NPINS-1:0]     prev_w;
  logic [NPINS-1:0]     trig_w;
  logic [MODE_BITS-1:0] mode_w;
  logic [NPINS-1:0]     mask_w;
  logic [NPINS-1:0]     pend_w;
  logic                 irq_q;

  gpio_pin_sync #(.NPINS(NPINS)) i_sync (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .pin_i  (pin_i),
    .cur_o  (cur_w),
    .prev_o (prev_w)
  );

  gpio_trig_detect #(.NPINS(NPINS)) i_detect (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .mode_i (mode_w),
    .cur_i  (cur_w),
    .prev_i (prev_w),
    .trig_o (trig_w)
  );

  gpio_irq_regs #(.NPINS(NPINS), .DATA_W(DATA_W)) i_regs (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .trig_i    (trig_w),
    .rd_data_o (rd_data_o),
    .mode_o    (mode_w),
    .mask_o    (mask_w),
    .pend_o    (pend_w)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) irq_q <= 1'b0;
    else       irq_q <= |(pend_w & mask_w);
  end

  assign irq_o = irq_q;

  // R9
  irq_track_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (irq_o == $past(|(pend_w & mask_w))));

  // R1
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mask_w == '0) |=> !irq_o);
endmodule

// File: tb/test_gpio_irq_unit.sv
`timescale 1ns/1ps
module test_gpio_irq_unit;
  localparam int NP = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [NP-1:0] pin;
  logic          wr_en;
  logic [1:0]    wr_addr;
  logic [DW-1:0] wr_data;
  logic [1:0]    rd_addr;
  logic [DW-1:0] rd_data;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  gpio_irq_unit #(.NPINS(NP), .DATA_W(DW)) i_gpio_irq_unit (
    .clk_i(clk), .rst_i(rst), .pin_i(pin), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  // Behavioural reference
  int unsigned   m_mode [NP];
  logic [NP-1:0] m_mask, m_pend;
  logic          m_irq;
  logic [NP-1:0] hist [$];

  function automatic logic [DW-1:0] exp_rd(logic [1:0] a);
    logic [DW-1:0] r;
    r = '0;
    case (a)
      2'd0: for (int i = 0; i < NP; i++) r = r | (DW'(m_mode[i]) << (3*i));
      2'd1: r = DW'(m_mask);
      2'd2: r = DW'(m_pend);
      default: r = DW'(m_pend & m_mask);
    endcase
    return r;
  endfunction

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [NP-1:0] cur, prv, trig, ack, pn;
    logic irn;
    if (rst) begin
      for (int i = 0; i < NP; i++) m_mode[i] = 0;
      m_mask = '0; m_pend = '0; m_irq = 1'b0;
      hist = '{8'h00, 8'h00, 8'h00};
    end else begin
      cur = hist[1];
      prv = hist[2];
      trig = '0;
      for (int i = 0; i < NP; i++) begin
        case (m_mode[i])
          1: trig[i] = cur[i];
          2: trig[i] = !cur[i];
          3: trig[i] = 1'b1;
          4: trig[i] = cur[i] && !prv[i];
          5: trig[i] = !cur[i] && prv[i];
          6: trig[i] = cur[i] != prv[i];
          default: trig[i] = 1'b0;
        endcase
      end
      ack = (wr_en && wr_addr == 2'd2) ? wr_data[NP-1:0] : '0;
      irn = |(m_pend & m_mask);
      pn  = (m_pend & ~ack) | trig;
      if (wr_en && wr_addr == 2'd0)
        for (int i = 0; i < NP; i++) m_mode[i] = (wr_data >> (3*i)) & 7;
      if (wr_en && wr_addr == 2'd1) m_mask = wr_data[NP-1:0];
      m_pend = pn;
      m_irq  = irn;
      hist.push_front(pin);
      void'(hist.pop_back());
    end
    #5;
    chk(phase, "rd_data vs model", rd_data, exp_rd(rd_addr));
    chk(phase, "irq vs model", DW'(irq), DW'(m_irq));
  end

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(string tag, logic [1:0] a, logic [DW-1:0] exp);
    rd_addr = a;
    #1;
    chk(tag, "directed read", rd_data, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pin = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    phase = "R1";
    peek("R1", 2'd0, 32'h0);
    peek("R1", 2'd1, 32'h0);
    peek("R1", 2'd2, 32'h0);
    peek("R1", 2'd3, 32'h0);
    chk("R1", "irq", DW'(irq), 32'h0);

    // R10 selector layout: pin i at bits 3i+2..3i, modes 0..7 across pins
    phase = "R10";
    wr(2'd0, 32'h00FA_C688);
    peek("R10", 2'd0, 32'h00FA_C688);
    wr(2'd1, 32'hFFFF_FFFF);
    peek("R10", 2'd1, 32'h0000_00FF);

    // R3 R5 R2 mixed traffic against the model
    phase = "R5";
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      pin = NP'($urandom);
      rd_addr = 2'($urandom);
      wr_en = ($urandom % 5) == 0;
      wr_addr = 2'($urandom);
      wr_data = $urandom;
    end
    @(negedge clk);
    wr_en = 1'b0;

    // R6 latency: clear everything, then a single rising edge on pin0
    phase = "R6";
    pin = '0;
    wr(2'd0, 32'h0);
    idle(3);
    wr(2'd2, 32'hFF);
    wr(2'd1, 32'h01);
    wr(2'd0, 32'h4);
    idle(3);
    peek("R6", 2'd2, 32'h0);
    pin = 8'h01;
    @(negedge clk);
    @(negedge clk);
    peek("R6", 2'd2, 32'h0);
    @(negedge clk);
    peek("R6", 2'd2, 32'h1);
    chk("R9", "irq before its register", DW'(irq), 32'h0);
    @(negedge clk);
    chk("R9", "irq one edge after status", DW'(irq), 32'h1);

    // R3 level low: flag re-asserts through a clear; R7 zero and same-cycle rules
    phase = "R7";
    pin = 8'h01;
    wr(2'd0, 32'h80);
    idle(3);
    wr(2'd2, 32'h0);
    peek("R7", 2'd2, 32'h05);
    wr(2'd2, 32'h04);
    peek("R3", 2'd2, 32'h05);
    pin = 8'h05;
    idle(3);
    wr(2'd2, 32'h05);
    peek("R7", 2'd2, 32'h0);

    // R8 mask gating keeps selector and pending flag
    phase = "R8";
    pin = 8'h01;
    wr(2'd1, 32'h04);
    idle(3);
    peek("R8", 2'd3, 32'h04);
    wr(2'd1, 32'h0);
    @(negedge clk);
    chk("R8", "irq after mask clear", DW'(irq), 32'h0);
    peek("R8", 2'd3, 32'h0);
    peek("R8", 2'd0, 32'h80);
    peek("R8", 2'd2, 32'h04);

    // R10 writes to the status address change nothing
    phase = "R10";
    wr(2'd3, 32'hFFFF_FFFF);
    peek("R10", 2'd1, 32'h0);
    peek("R10", 2'd0, 32'h80);

    // R2 reserved code 7 behaves as off
    phase = "R2";
    wr(2'd0, 32'h1C0);
    wr(2'd2, 32'hFF);
    idle(4);
    peek("R2", 2'd2, 32'h0);

    // R4 always mode raises the flag one edge after the selector write
    phase = "R4";
    wr(2'd0, 32'h600);
    peek("R4", 2'd2, 32'h0);
    @(negedge clk);
    peek("R4", 2'd2, 32'h08);

    idle(3);
    finished = 1;
    summary();
    $finish;
  end
endmodule